// File: doc/BRIEF.md
# Half-Integer Dual-Edge Clock Divider

This block produces a slower clock whose period is N/2 periods of the input clock, where N is any odd count of three or more (five by default, so the ratio is 2.5). It counts every transition of the input clock, rising and falling alike, so one output period covers exactly N input half-periods. Storage elements clocked on both input edges are required for this.

A rising-edge phase counter decides when an output high run starts on a rising input edge. It also decides when a run starts on a falling input edge, and a falling-edge register retimes that decode. The divided clock is the OR of the two path registers. Each high run lasts two input half-periods, so the duty cycle at the default ratio is 40%. Successive output rising edges alternate between rising and falling input edges. Because of this, any duty error of the input clock appears as a fixed, repeating offset in the output edge timing. A second output changes level once for every input transition, which gives a marker at the raw edge rate. An active-high asynchronous reset silences both outputs.

Top module: `hdiv_top`

## Requirements
- R1: Successive rising edges of divOut are N input half-periods apart (20 ns with N=5 and a 125 MHz, 50% duty input).
- R2: Each high run of divOut lasts exactly two input half-periods (one input period), and each path register stays high for one period of its own clock edge.
- R3: Output rising edges alternate in alignment. The first follows a rising input edge, the next a falling input edge, and so on.
- R4: Let h number the input transitions from the first rising edge after reset release, with h=0 at that edge. divOut is high in half-period h exactly when h mod N is 0 or 1.
- R5: The rising-edge path and the falling-edge path are never high at the same time, so the OR has no overlap at a handover.
- R6: While rst is high, divOut and edgeMark are low. They go low at once when rst rises, whatever the input clock is doing.
- R7: After rst falls, the first counted edge is the first rising input edge, and divOut rises there. A falling edge that comes before that rising edge leaves divOut low.
- R8: After rst falls, edgeMark changes level once on every input transition and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkIn | input | 1 | Input clock. Both of its edges are counted |
| rst | input | 1 | Asynchronous reset, active high |
| divOut | output | 1 | Divided clock, ratio N/2 |
| edgeMark | output | 1 | Changes level on every input transition |

## Verification
Two functions can meet in one instant: the asynchronous reset and the counting path. The bench raises rst one nanosecond into a divOut high run, while a path register holds the output high. It then checks that divOut and edgeMark fall at once and stay low across further input edges. The second meeting is reset release and the falling-edge path: rst is released while clkIn is high, so a falling edge arrives before any rising edge. The bench checks that this falling edge moves edgeMark but does not raise divOut, and that divOut rises on the following rising edge.

// File: rtl/hdiv_pkg.sv
package hdiv_pkg;

  // Strobes from the rising-edge phase counter to the path registers.
  typedef struct packed {
    logic fallHit;  // a high run starts at the coming falling edge
    logic riseHit;  // a high run starts at the coming rising edge
  } hdiv_strobe_t;

  // Number of paths: one per input edge polarity.
  localparam int HDIV_PATHS = 2;

endpackage

// File: rtl/hdiv_ctrl.sv
module hdiv_ctrl
  import hdiv_pkg::*;
#(
  parameter int N = 5
) (
  input  logic         clkIn,
  input  logic         rst,
  output hdiv_strobe_t strobes
);

  localparam int CW = (N > 2) ? $clog2(N) : 2;
  localparam logic [CW-1:0] PH_RISE = CW'(N - 2);
  localparam logic [CW-1:0] PH_FALL = CW'(N - 1);

  // The phase counts half-periods modulo N, sampled at rising edges.
  // It steps by two per input period.
  logic [CW-1:0] phase;
  logic [CW-1:0] phaseNext;

  always_comb begin
    if (phase >= PH_RISE) phaseNext = phase - PH_RISE;
    else                  phaseNext = phase + CW'(2);
  end

  // Reset to N-2, so that the first rising edge lands on phase 0.
  always_ff @(posedge clkIn or posedge rst) begin
    if (rst) phase <= PH_RISE;
    else     phase <= phaseNext;
  end

  always_comb begin
    strobes.riseHit = (phase == PH_RISE);
    strobes.fallHit = (phase == PH_FALL);
  end

endmodule

// File: rtl/hdiv_edge_reg.sv
module hdiv_edge_reg #(
  parameter bit FALLING = 1'b0
) (
  input  logic clkIn,
  input  logic rst,
  input  logic setIn,
  output logic hitQ,
  output logic togQ
);

  generate
    if (FALLING) begin : g_fall
      always_ff @(negedge clkIn or posedge rst) begin
        if (rst) begin
          hitQ <= 1'b0;
          togQ <= 1'b0;
        end else begin
          hitQ <= setIn;
          togQ <= ~togQ;
        end
      end
    end else begin : g_rise
      always_ff @(posedge clkIn or posedge rst) begin
        if (rst) begin
          hitQ <= 1'b0;
          togQ <= 1'b0;
        end else begin
          hitQ <= setIn;
          togQ <= ~togQ;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/hdiv_datapath.sv
module hdiv_datapath
  import hdiv_pkg::*;
(
  input  logic                  clkIn,
  input  logic                  rst,
  input  hdiv_strobe_t          strobes,
  output logic [HDIV_PATHS-1:0] pathHigh,
  output logic                  divOut,
  output logic                  edgeMark
);

  logic [HDIV_PATHS-1:0] setVec;
  logic [HDIV_PATHS-1:0] togVec;

  // Index 0 is the rising path, index 1 the falling path.
  assign setVec = {strobes.fallHit, strobes.riseHit};

  for (genvar g = 0; g < HDIV_PATHS; g++) begin : g_path
    hdiv_edge_reg #(.FALLING(g == 1)) u_reg (
      .clkIn (clkIn),
      .rst   (rst),
      .setIn (setVec[g]),
      .hitQ  (pathHigh[g]),
      .togQ  (togVec[g])
    );
  end

  assign divOut   = |pathHigh;
  assign edgeMark = ^togVec;

endmodule

// File: rtl/hdiv_top.sv
module hdiv_top
  import hdiv_pkg::*;
#(
  parameter int N = 5
) (
  input  logic clkIn,
  input  logic rst,
  output logic divOut,
  output logic edgeMark
);

  hdiv_strobe_t          strobes;
  logic [HDIV_PATHS-1:0] pathHigh;

  hdiv_ctrl #(.N(N)) u_ctrl (
    .clkIn   (clkIn),
    .rst     (rst),
    .strobes (strobes)
  );

  hdiv_datapath u_dp (
    .clkIn    (clkIn),
    .rst      (rst),
    .strobes  (strobes),
    .pathHigh (pathHigh),
    .divOut   (divOut),
    .edgeMark (edgeMark)
  );

endmodule

// File: rtl/hdiv_checks.sv
module hdiv_checks #(
  parameter int N = 5
) (
  input logic       clkIn,
  input logic       rst,
  input logic       divOut,
  input logic       edgeMark,
  input logic [1:0] pathHigh
);

  localparam int GW = $clog2(N + 2) + 1;

  logic [GW-1:0] gap;
  logic          seen;
  logic          prevHigh;

  // Counts rising edges between starts of the rising-path high run.
  always_ff @(posedge clkIn or posedge rst) begin
    if (rst) begin
      gap      <= '0;
      seen     <= 1'b0;
      prevHigh <= 1'b0;
    end else begin
      prevHigh <= pathHigh[0];
      if (pathHigh[0] && !prevHigh) begin
        if (seen) AST_RISE_SPACING: assert (gap == GW'(N)); // R1
        gap  <= GW'(1);
        seen <= 1'b1;
      end else if (gap != '1) begin
        gap <= gap + GW'(1);
      end
    end
  end

  always @(posedge clkIn) begin
    if (rst) AST_RESET_QUIET: assert (!divOut && !edgeMark); // R6
  end

  AST_PATHS_DISJOINT: assert property (@(posedge clkIn) disable iff (rst)
    !(pathHigh[0] && pathHigh[1])); // R5

  AST_PATHS_DISJOINT_NEG: assert property (@(negedge clkIn) disable iff (rst)
    !(pathHigh[0] && pathHigh[1])); // R5

  AST_RISE_ONE_PERIOD: assert property (@(posedge clkIn) disable iff (rst)
    $rose(pathHigh[0]) |=> !pathHigh[0]); // R2

  AST_FALL_ONE_PERIOD: assert property (@(negedge clkIn) disable iff (rst)
    $rose(pathHigh[1]) |=> !pathHigh[1]); // R2

endmodule

bind hdiv_top hdiv_checks #(.N(N)) u_checks (
  .clkIn    (clkIn),
  .rst      (rst),
  .divOut   (divOut),
  .edgeMark (edgeMark),
  .pathHigh (pathHigh)
);

// File: tb/test_hdiv_top.sv
`timescale 1ns/1ps
module test_hdiv_top;

  localparam int N       = 5;
  localparam int HALF_PS = 4000;       // 125 MHz, half period in ps
  localparam int WALK    = 110;        // half-periods walked
  localparam bit EXP_HALF [10] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0,
                                   1'b1, 1'b1, 1'b0, 1'b0, 1'b0};

  logic clkIn = 1'b0;
  logic rst   = 1'b1;
  logic divOut;
  logic edgeMark;

  int errors = 0;
  int checks = 0;

  bit  logOn = 1'b0;
  real riseT [64];
  real fallT [64];
  bit  riseClk [64];
  int  nRise = 0;
  int  nFall = 0;
  int  markChg = 0;
  int  clkChg = 0;

  hdiv_top #(.N(N)) i_hdiv_top (
    .clkIn    (clkIn),
    .rst      (rst),
    .divOut   (divOut),
    .edgeMark (edgeMark)
  );

  always #4 clkIn = ~clkIn;

  always @(posedge divOut) if (logOn && nRise < 64) begin
    riseT[nRise]   = $realtime;
    riseClk[nRise] = clkIn;
    nRise++;
  end

  always @(negedge divOut) if (logOn && nFall < 64) begin
    fallT[nFall] = $realtime;
    nFall++;
  end

  always @(edgeMark) if (logOn) markChg++;
  always @(clkIn)    if (logOn) clkChg++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // Reset held across several edges: R6
    repeat (3) @(posedge clkIn);
    @(negedge clkIn); #1;
    check(divOut == 1'b0, "R6 reset divOut", int'(divOut), 0);
    check(edgeMark == 1'b0, "R6 reset edgeMark", int'(edgeMark), 0);

    // Release while clkIn is low; h=0 is the next rising edge
    rst   = 1'b0;
    logOn = 1'b1;
    for (int i = 0; i < WALK; i++) begin
      @(clkIn); #1;
      check(divOut == EXP_HALF[i % 10], "R4 R5 half-period pattern",
            int'(divOut), int'(EXP_HALF[i % 10]));
    end
    logOn = 1'b0;

    // R1: rising edge spacing over more than 20 periods
    check(nRise >= 21, "R1 period count", nRise, 21);
    for (int j = 1; j < nRise; j++) begin
      int d;
      d = int'((riseT[j] - riseT[j-1]) * 1000.0);
      check(d == N * HALF_PS, "R1 rise interval", d, N * HALF_PS);
    end
    // R2: high time
    for (int j = 0; j < nRise && j < nFall; j++) begin
      int d;
      d = int'((fallT[j] - riseT[j]) * 1000.0);
      check(d == 2 * HALF_PS, "R2 high time", d, 2 * HALF_PS);
    end
    // R3: alignment alternates, first on a rising input edge
    for (int j = 0; j < nRise; j++) begin
      check(riseClk[j] == ((j % 2) == 0), "R3 edge alignment",
            int'(riseClk[j]), int'((j % 2) == 0));
    end
    // R8: one edgeMark change per input transition
    check(markChg == clkChg, "R8 edgeMark changes", markChg, clkChg);

    // Async reset in the middle of a high run: R6
    @(posedge divOut); #1;
    rst = 1'b1;
    #1;
    check(divOut == 1'b0, "R6 async reset divOut", int'(divOut), 0);
    check(edgeMark == 1'b0, "R6 async reset edgeMark", int'(edgeMark), 0);
    for (int k = 0; k < 4; k++) begin
      @(clkIn); #1;
      check(divOut == 1'b0, "R6 held reset divOut", int'(divOut), 0);
    end

    // Release while clkIn is high: R7
    @(posedge clkIn); #1;
    rst = 1'b0;
    @(negedge clkIn); #1;
    check(divOut == 1'b0, "R7 falling edge before first rise", int'(divOut), 0);
    check(edgeMark == 1'b1, "R8 edgeMark on falling edge", int'(edgeMark), 1);
    @(posedge clkIn); #1;
    check(divOut == 1'b1, "R7 first rise after release", int'(divOut), 1);
    check(edgeMark == 1'b0, "R8 edgeMark on rising edge", int'(edgeMark), 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule